// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block steers interrupts to a group of up to sixteen processors. Thirty-two device lines feed a shared pending word. A fixed rule turns each line into a priority level from 1 to 15. Shared requests that survive a disable mask go to one selectable target processor. Each processor also owns a local pending word. That word holds software interrupts, written through a small register port, and device interrupts addressed to that processor alone.

Every cycle the router works out, for each processor, the highest level that processor is owed. A level is offered only when nothing is outstanding at that processor. The offer appears as a 4-bit level, held steady, together with a one-cycle request strobe, and it stays until the processor acknowledges it. A processor that has gone to sleep is woken by any level that is due to it, even when an earlier interrupt is still outstanding.

Events and register writes update the pending state on the clock edge that samples them. The resulting offer appears one edge later.

Top module: `mp_irq_router`

## Requirements
- R1: Line n maps to level n mod 16, so lines 0 and 16 have level 0 and never produce an interrupt.
- R2: An event with `ev_cpu` all ones sets (`ev_assert`=1) or clears shared pending bit `ev_line`. The highest level among shared pending bits not disabled is owed to the target processor only.
- R3: A write with `wr_sel`=2 replaces the disable mask, where a 1 disables that line. A write with `wr_sel`=3 loads the target processor from the low bits of `wr_data`. After reset the target is processor 0.
- R4: A write with `wr_sel`=0 ORs bits 31..17 of `wr_data` into the local word of processor `wr_cpu`. Bits 16..0 of the write are ignored.
- R5: A write with `wr_sel`=1 clears, in processor `wr_cpu`'s local word, every bit set in `wr_data`. Bits cleared this way are gone from the evaluation of the next cycle.
- R6: An event with `ev_cpu` below the processor count sets or clears bit level(`ev_line`) of that processor's local word, provided that level is nonzero.
- R7: A local bit j in 1..15 stands for level j, and a local bit j in 17..31 stands for level j−16. A processor is owed the higher of its local maximum and, if it is the target, the shared maximum.
- R8: When a processor is owed a nonzero level and has nothing outstanding, the next cycle shows that level on its `irq_level` slice with a one-cycle `irq_req`. While the level is outstanding it is held, and newer levels wait.
- R9: `ack` removes the outstanding level, so the next cycle shows 0. A new offer appears one cycle after that at the earliest.
- R10: `halt_req` sets `cpu_halted` on the next cycle. A nonzero level owed to a halted processor clears `cpu_halted` and pulses `wake`. The wake takes priority over a halt request in the same cycle.
- R11: Reset clears all pending words, the disable mask, levels, `irq_req` and `wake`. It leaves processor 0 running and every other processor halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Device event strobe |
| ev_line | input | 5 | Device line of the event |
| ev_assert | input | 1 | 1 raises the line, 0 lowers it |
| ev_cpu | input | 5 | Processor index of the event; all ones selects the shared path |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 set soft, 1 clear soft, 2 disable mask, 3 target |
| wr_cpu | input | 4 | Processor addressed by soft writes |
| wr_data | input | 32 | Write data |
| ack | input | 16 | Per-processor acknowledge |
| halt_req | input | 16 | Per-processor halt request |
| irq_level | output | 64 | 4-bit level per processor, processor i in bits 4i+3..4i |
| irq_req | output | 16 | One-cycle offer strobe per processor |
| wake | output | 16 | One-cycle wake pulse per processor |
| cpu_halted | output | 16 | Halt state per processor |

## Verification
The hardest case to reach from the ports is a level that changes while a processor still has one outstanding. The newer level has to wait, and after the acknowledge it has to be offered without a gap of more than one cycle. A related case is a halted processor that receives a level while its previous interrupt is still unacknowledged. Directed sequences stack soft writes on an unacknowledged level, steer the shared level onto a halted target and race halt requests against wakes. Random traffic then runs sparse acknowledges against dense events, so that queued levels build up. A bench model follows every processor cycle by cycle.

// File: rtl/mp_irq_router.sv
module mp_irq_router #(
  parameter int NCPU  = 16,
  parameter int NLINE = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_valid,
  input  logic [$clog2(NLINE)-1:0] ev_line,
  input  logic                     ev_assert,
  input  logic [$clog2(NCPU):0]    ev_cpu,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [$clog2(NCPU)-1:0]  wr_cpu,
  input  logic [31:0]              wr_data,
  input  logic [NCPU-1:0]          ack,
  input  logic [NCPU-1:0]          halt_req,
  output logic [NCPU*4-1:0]        irq_level,
  output logic [NCPU-1:0]          irq_req,
  output logic [NCPU-1:0]          wake,
  output logic [NCPU-1:0]          cpu_halted
);
  localparam int CPU_W = $clog2(NCPU);
  localparam logic [CPU_W:0] SHARED = '1;
  localparam logic [31:0] SOFT_MASK = 32'hFFFE_0000;

  function automatic logic [3:0] line_level(input int n);
    return 4'(n % 16);
  endfunction

  function automatic logic [3:0] local_level(input logic [31:0] w);
    logic [3:0] lv = '0;
    for (int j = 1; j < 16; j++) if (w[j]) lv = 4'(j);
    for (int j = 17; j < 32; j++) if (w[j] && 4'(j - 16) > lv) lv = 4'(j - 16);
    return lv;
  endfunction

  logic [NLINE-1:0] gpend_q, gdis_q;
  logic [CPU_W-1:0] target_q;
  logic [3:0]       glvl;

  always_comb begin
    glvl = '0;
    for (int b = 0; b < NLINE; b++)
      if (gpend_q[b] && !gdis_q[b] && line_level(b) > glvl) glvl = line_level(b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpend_q  <= '0;
      gdis_q   <= '0;
      target_q <= '0;
    end else begin
      if (ev_valid && ev_cpu == SHARED) gpend_q[ev_line] <= ev_assert;
      if (wr_en && wr_sel == 2'd2) gdis_q <= wr_data[NLINE-1:0];
      if (wr_en && wr_sel == 2'd3) target_q <= wr_data[CPU_W-1:0];
    end
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic [31:0] lp_q, lp_d;
    logic [3:0]  lvl_q, want, gshare, lloc;
    logic [3:0]  ev_lv;

    assign ev_lv  = line_level(int'(ev_line));
    assign gshare = (target_q == CPU_W'(i)) ? glvl : 4'd0;
    assign lloc   = local_level(lp_q);
    assign want   = (lloc > gshare) ? lloc : gshare;

    always_comb begin
      lp_d = lp_q;
      if (ev_valid && ev_cpu == (CPU_W+1)'(i) && ev_lv != 0) lp_d[ev_lv] = ev_assert;
      if (wr_en && wr_cpu == CPU_W'(i)) begin
        if (wr_sel == 2'd0) lp_d = lp_d | (wr_data & SOFT_MASK);
        if (wr_sel == 2'd1) lp_d = lp_d & ~wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lp_q          <= '0;
        lvl_q         <= '0;
        irq_req[i]    <= 1'b0;
        wake[i]       <= 1'b0;
        cpu_halted[i] <= (i != 0);
      end else begin
        lp_q       <= lp_d;
        irq_req[i] <= 1'b0;
        wake[i]    <= 1'b0;
        if (ack[i]) lvl_q <= '0;
        else if (want != 0 && lvl_q == 0) begin
          lvl_q      <= want;
          irq_req[i] <= 1'b1;
        end
        if (want != 0 && cpu_halted[i]) begin
          cpu_halted[i] <= 1'b0;
          wake[i]       <= 1'b1;
        end else if (halt_req[i]) cpu_halted[i] <= 1'b1;
      end
    end

    assign irq_level[i*4 +: 4] = lvl_q;

    p_offer_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] |-> ($past(irq_level[i*4 +: 4]) == 4'd0 && irq_level[i*4 +: 4] != 4'd0));
    p_level_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level[i*4 +: 4] != 4'd0 && !ack[i]) |=> $stable(irq_level[i*4 +: 4]));
    p_ack_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack[i] |=> irq_level[i*4 +: 4] == 4'd0);
    p_wake_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wake[i] |-> (!cpu_halted[i] && $past(cpu_halted[i])));
    p_halt_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_halted[i])) |-> $past(halt_req[i]));
  end
endmodule

// File: tb/mp_irq_router_bench.sv
module mp_irq_router_bench;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, ev_valid, ev_assert, wr_en;
  logic [4:0] ev_line, ev_cpu;
  logic [1:0] wr_sel;
  logic [3:0] wr_cpu;
  logic [31:0] wr_data;
  logic [15:0] ack, halt_req, irq_req, wake, cpu_halted;
  logic [63:0] irq_level;

  mp_irq_router u_mp_irq_router (.clk, .rst_n, .ev_valid, .ev_line, .ev_assert, .ev_cpu,
    .wr_en, .wr_sel, .wr_cpu, .wr_data, .ack, .halt_req, .irq_level, .irq_req, .wake, .cpu_halted);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_lp[16];
  logic [3:0]  m_lvl[16];
  logic [15:0] m_req, m_wake, m_halt;
  logic [31:0] m_gp, m_gd;
  logic [3:0]  m_tg;

  function automatic logic [3:0] f_line(input int n);
    return 4'(n % 16);
  endfunction
  function automatic logic [3:0] f_loc(input logic [31:0] w);
    logic [3:0] r = 0;
    for (int j = 1; j < 32; j++)
      if (w[j] && j != 16) begin
        if (j < 16 && 4'(j) > r) r = 4'(j);
        if (j > 16 && 4'(j - 16) > r) r = 4'(j - 16);
      end
    return r;
  endfunction
  function automatic logic [3:0] f_glob(input logic [31:0] p, input logic [31:0] d);
    logic [3:0] r = 0;
    for (int b = 0; b < 32; b++) if (p[b] && !d[b] && f_line(b) > r) r = f_line(b);
    return r;
  endfunction
  function automatic logic [3:0] lv(input int c);
    return irq_level[c*4 +: 4];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 16; i++) begin m_lp[i] = 0; m_lvl[i] = 0; end
    m_req = 0; m_wake = 0; m_halt = 16'hFFFE; m_gp = 0; m_gd = 0; m_tg = 0;
  endtask

  task automatic m_step();
    logic [3:0] dem[16];
    logic [3:0] g;
    g = f_glob(m_gp, m_gd);
    for (int i = 0; i < 16; i++) begin
      dem[i] = f_loc(m_lp[i]);
      if (m_tg == 4'(i) && g > dem[i]) dem[i] = g;
    end
    if (ev_valid && ev_cpu == 5'h1F) m_gp[ev_line] = ev_assert;
    if (ev_valid && ev_cpu < 16 && f_line(int'(ev_line)) != 0)
      m_lp[ev_cpu[3:0]][f_line(int'(ev_line))] = ev_assert;
    if (wr_en) case (wr_sel)
      2'd0: m_lp[wr_cpu] = m_lp[wr_cpu] | (wr_data & 32'hFFFE0000);
      2'd1: m_lp[wr_cpu] = m_lp[wr_cpu] & ~wr_data;
      2'd2: m_gd = wr_data;
      default: m_tg = wr_data[3:0];
    endcase
    m_req = 0; m_wake = 0;
    for (int i = 0; i < 16; i++) begin
      if (ack[i]) m_lvl[i] = 0;
      else if (dem[i] != 0 && m_lvl[i] == 0) begin m_lvl[i] = dem[i]; m_req[i] = 1; end
      if (dem[i] != 0 && m_halt[i]) begin m_halt[i] = 0; m_wake[i] = 1; end
      else if (halt_req[i]) m_halt[i] = 1;
    end
  endtask

  task automatic tick();
    m_step();
    @(posedge clk); #1;
    for (int i = 0; i < 16; i++) chk(32'(lv(i)), 32'(m_lvl[i]), "R8 level vs model");
    chk(32'(irq_req), 32'(m_req), "R8 irq_req vs model");
    chk(32'(wake), 32'(m_wake), "R10 wake vs model");
    chk(32'(cpu_halted), 32'(m_halt), "R10 cpu_halted vs model");
    @(negedge clk);
  endtask

  task automatic idle();
    ev_valid = 0; ev_line = 0; ev_assert = 0; ev_cpu = 0;
    wr_en = 0; wr_sel = 0; wr_cpu = 0; wr_data = 0; ack = 0; halt_req = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] c, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_cpu = c; wr_data = d; tick(); idle();
  endtask

  task automatic ev(input int line, input logic a, input logic [4:0] c);
    ev_valid = 1; ev_line = 5'(line); ev_assert = a; ev_cpu = c; tick(); idle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(); rst_n = 0; m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(32'(irq_level), 0, "R11 levels after reset");
    chk(32'(cpu_halted), 32'hFFFE, "R11 halted after reset");
    chk(32'(irq_req | wake), 0, "R11 no strobes after reset");
    tick();
    wr(2'd0, 4'd2, 32'h0001_FFFF); tick(); tick();
    chk(32'(lv(2)), 0, "R4 low bits ignored");
    chk(32'(cpu_halted[2]), 1, "R4 low bits do not wake");
    wr(2'd0, 4'd2, 32'h0010_0000); tick();
    chk(32'(lv(2)), 4, "R7 soft bit 20 is level 4");
    chk(32'(irq_req[2]), 1, "R8 request strobe");
    chk(32'(wake[2]), 1, "R10 wake pulse");
    wr(2'd0, 4'd2, 32'h8000_0000); tick();
    chk(32'(lv(2)), 4, "R8 outstanding level held");
    ack[2] = 1; tick(); idle();
    chk(32'(lv(2)), 0, "R9 ack clears level");
    tick();
    chk(32'(lv(2)), 15, "R7 waiting level 15 offered");
    ack[2] = 1; wr(2'd1, 4'd2, 32'hFFFF_FFFF); tick(); tick();
    chk(32'(lv(2)), 0, "R5 clear soft removes pending");
    ev(21, 1, 5'h1F); tick();
    chk(32'(lv(0)), 5, "R2 shared line 21 level 5 to target 0");
    chk(32'(lv(1)), 0, "R2 non-target gets nothing");
    ack[0] = 1; wr(2'd2, 4'd0, 32'h0020_0000); tick(); tick();
    chk(32'(lv(0)), 0, "R3 disabled line not routed");
    ev(16, 1, 5'h1F); tick(); tick();
    chk(32'(lv(0)), 0, "R1 line 16 has no level");
    wr(2'd3, 4'd0, 32'd3); wr(2'd2, 4'd0, 32'd0); tick();
    chk(32'(lv(3)), 5, "R3 new target 3 receives level 5");
    chk(32'(lv(0)), 0, "R3 old target idle");
    ev(9, 1, 5'd5); tick();
    chk(32'(lv(5)), 9, "R6 local device line 9 level 9");
    halt_req[0] = 1; tick(); idle();
    chk(32'(cpu_halted[0]), 1, "R10 halt request");
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom % 3 == 0) begin
        ev_valid = 1; ev_line = 5'($urandom); ev_assert = 1'($urandom % 4 != 0);
        ev_cpu = ($urandom % 3 == 0) ? 5'h1F : 5'($urandom % 16);
      end
      if ($urandom % 6 == 0) begin
        wr_en = 1; wr_sel = 2'($urandom); wr_cpu = 4'($urandom); wr_data = $urandom;
        if (wr_sel == 2'd2) wr_data = wr_data & $urandom;
      end
      ack = 16'($urandom & $urandom & $urandom);
      halt_req = 16'($urandom & $urandom & $urandom & $urandom);
      tick();
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule